// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block answers the command bytes a host sends to a serial keyboard and turns key events into scan bytes. Host command bytes arrive on a one-cycle strobe. Key events arrive as a 7-bit code, a press or release flag and a kind field that marks the two lock keys. Every response byte and key byte goes into a small circular queue. A reader drains the queue through a head-of-queue output and a pop strobe.

Two commands empty the queue and load a fixed answer: the identify command and the layout query. The LED command makes the next command byte act as a data byte that is consumed and otherwise has no effect. The two lock keys each keep a two-bit toggle. The toggle hides the second press and the first release of each lock cycle, so a held lock key reads as latched. In one cycle the block can take a command, a key event and a pop together. The queue then applies the pop, then any clear, then the command's bytes, then the key byte.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset the queue is empty, `not_empty` is 0, `rd_data` is 0x00 and both lock toggles and the LED-skip state are cleared.
- R2: Command 0x01 discards the queue contents and then queues 0xFF, 0x04, 0x7F in that order.
- R3: Command 0x0E arms the LED skip. The next command byte, whatever its value, is consumed with no effect on the queue. The skip then disarms, so a later 0x01 acts normally.
- R4: Commands 0x07 and 0x0F discard the queue contents and then queue 0xFE followed by the layout byte.
- R5: The layout byte equals `layout_sw`. The value 0xFF means unconfigured, and in that case the layout byte is 0x21.
- R6: Any other command byte leaves the queue contents unchanged.
- R7: A key event of kind 0 or 3 queues {release, code}: bit 7 is 1 for a release and 0 for a press, and bits 6:0 hold the code.
- R8: Kind 1 and kind 2 select lock toggle 0 and lock toggle 1. A press XORs the toggle with 1 and a release XORs it with 2. The event is dropped when a press leaves the toggle at 2 or a release leaves it at 3. Otherwise it is queued as in R7.
- R9: The queue holds 16 bytes. A byte offered to a full queue is dropped, and the bytes already stored are kept.
- R10: With the queue empty, `rd_data` is 0x00, and a pop changes nothing.
- R11: Bytes leave in the order they entered. `not_empty` is 1 exactly when at least one byte is stored. A pop removes the head byte at the clock edge.
- R12: When a command and a key event arrive in the same cycle, the command's bytes are queued first and the key byte after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Host command byte strobe |
| cmd_byte | input | 8 | Host command byte |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 7 | Key code |
| key_release | input | 1 | 1 = release, 0 = press |
| key_kind | input | 2 | 0/3 ordinary key, 1 lock 0, 2 lock 1 |
| layout_sw | input | 8 | Layout switch value, 0xFF = unconfigured |
| pop | input | 1 | Remove the head byte |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| not_empty | output | 1 | Queue holds at least one byte |

## Verification
On every cycle the assertions check a set of properties. The count never exceeds the depth. An empty queue shows 0x00 at the head. An armed LED skip always disarms on the next command. The identify, layout and ignored commands each leave the queue in the state their requirement predicts in the following cycle. A lone ordinary key into an empty queue appears at the head with the release flag in bit 7. The bench's scenarios cover what a single cycle cannot show: byte order over a full drain, drops at the depth limit, the four-step toggle sequence of the lock keys, the layout default, and the combined command-plus-key cycle.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam logic [7:0] CMD_IDENT    = 8'h01;
  localparam logic [7:0] CMD_LED      = 8'h0E;
  localparam logic [7:0] CMD_LAYOUT_A = 8'h07;
  localparam logic [7:0] CMD_LAYOUT_B = 8'h0F;
  localparam logic [7:0] RSP_ID0      = 8'hFF;
  localparam logic [7:0] RSP_ID1      = 8'h04;
  localparam logic [7:0] RSP_ID2      = 8'h7F;
  localparam logic [7:0] RSP_LAYOUT   = 8'hFE;
  localparam logic [7:0] LAYOUT_UNSET = 8'hFF;
  localparam logic [7:0] LAYOUT_DFLT  = 8'h21;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_LOCK0 = 2'd1,
    KIND_LOCK1 = 2'd2,
    KIND_PLAIN2 = 2'd3
  } key_kind_e;

  // Layout byte reported for a switch value
  function automatic logic [7:0] layout_resolve(input logic [7:0] sw);
    return (sw == LAYOUT_UNSET) ? LAYOUT_DFLT : sw;
  endfunction

  // Scan byte for a key event
  function automatic logic [7:0] scan_byte(input logic rel, input logic [6:0] code);
    return {rel, code};
  endfunction

  // Next lock toggle value
  function automatic logic [1:0] lock_next(input logic [1:0] t, input logic rel);
    return rel ? (t ^ 2'b10) : (t ^ 2'b01);
  endfunction

  // Whether an event leaving the toggle at nxt is hidden
  function automatic logic lock_hide(input logic [1:0] nxt, input logic rel);
    return rel ? (nxt == 2'd3) : (nxt == 2'd2);
  endfunction
endpackage

// File: rtl/kbd_cmd_decode.sv
module kbd_cmd_decode
  import kbd_pkg::*;
#(
  parameter int RSP_MAX = 3,
  localparam int NW = $clog2(RSP_MAX + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [7:0]                cmd_byte,
  input  logic [7:0]                layout_sw,
  output logic                      q_clear,
  output logic [NW-1:0]             rsp_n,
  output logic [RSP_MAX-1:0][7:0]   rsp,
  output logic                      led_skip,
  output logic                      ev_led_consume
);
  logic led_arm;

  always_comb begin
    q_clear        = 1'b0;
    rsp_n          = '0;
    rsp            = '0;
    led_arm        = 1'b0;
    ev_led_consume = 1'b0;
    if (cmd_valid && led_skip) begin
      ev_led_consume = 1'b1;
    end else if (cmd_valid) begin
      unique case (cmd_byte)
        CMD_IDENT: begin
          q_clear = 1'b1;
          rsp_n   = NW'(3);
          rsp[0]  = RSP_ID0;
          rsp[1]  = RSP_ID1;
          rsp[2]  = RSP_ID2;
        end
        CMD_LED: led_arm = 1'b1;
        CMD_LAYOUT_A, CMD_LAYOUT_B: begin
          q_clear = 1'b1;
          rsp_n   = NW'(2);
          rsp[0]  = RSP_LAYOUT;
          rsp[1]  = layout_resolve(layout_sw);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              led_skip <= 1'b0;
    else if (ev_led_consume) led_skip <= 1'b0;
    else if (led_arm)        led_skip <= 1'b1;
  end
endmodule

// File: rtl/kbd_key_filter.sv
module kbd_key_filter
  import kbd_pkg::*;
#(
  parameter int LOCKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  input  logic [6:0] key_code,
  input  logic       key_release,
  input  logic [1:0] key_kind,
  output logic       key_push,
  output logic [7:0] key_out,
  output logic       ev_key_hidden
);
  logic [LOCKS-1:0] hide_vec;

  for (genvar i = 0; i < LOCKS; i++) begin : g_lock
    logic [1:0] tog;
    logic       sel;
    logic [1:0] nxt;
    assign sel         = key_valid && (key_kind == 2'(i + 1));
    assign nxt         = lock_next(tog, key_release);
    assign hide_vec[i] = sel && lock_hide(nxt, key_release);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tog <= 2'd0;
      else if (sel) tog <= nxt;
    end
  end

  assign ev_key_hidden = |hide_vec;
  assign key_push      = key_valid && !ev_key_hidden;
  assign key_out       = scan_byte(key_release, key_code);
endmodule

// File: rtl/kbd_byte_queue.sv
module kbd_byte_queue #(
  parameter int DEPTH = 16,
  parameter int SLOTS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   pop,
  input  logic [PW-1:0]          push_n,
  input  logic [SLOTS-1:0][7:0]  push_data,
  output logic [7:0]             rd_data,
  output logic                   not_empty,
  output logic [CW-1:0]          count,
  output logic                   ev_drop
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [AW-1:0] base_rp, base_wp;
  logic [CW:0]   base_cnt, room, n_ok;
  logic          pop_ok;

  assign pop_ok = pop && (count != '0);

  always_comb begin
    if (clear) begin
      base_cnt = '0;
      base_rp  = '0;
      base_wp  = '0;
    end else begin
      base_cnt = {1'b0, count} - (CW+1)'(pop_ok);
      base_rp  = rptr + AW'(pop_ok);
      base_wp  = wptr;
    end
    room    = (CW+1)'(DEPTH) - base_cnt;
    n_ok    = ((CW+1)'(push_n) < room) ? (CW+1)'(push_n) : room;
    ev_drop = (CW+1)'(push_n) > room;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < SLOTS; k++) begin
      if ((CW+1)'(k) < n_ok) mem[base_wp + AW'(k)] <= push_data[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      rptr  <= base_rp;
      wptr  <= base_wp + AW'(n_ok);
      count <= CW'(base_cnt + n_ok);
    end
  end

  assign not_empty = (count != '0);
  assign rd_data   = not_empty ? mem[rptr] : 8'h00;
endmodule

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder
  import kbd_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LOCKS = 2,
  localparam int RSP_MAX = 3,
  localparam int SLOTS = RSP_MAX + 1,
  localparam int NW = $clog2(RSP_MAX + 1),
  localparam int PW = $clog2(SLOTS + 1),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       key_valid,
  input  logic [6:0] key_code,
  input  logic       key_release,
  input  logic [1:0] key_kind,
  input  logic [7:0] layout_sw,
  input  logic       pop,
  output logic [7:0] rd_data,
  output logic       not_empty
);
  logic                    q_clear;
  logic [NW-1:0]           rsp_n;
  logic [RSP_MAX-1:0][7:0] rsp;
  logic                    led_skip, ev_led_consume;
  logic                    key_push, ev_key_hidden, ev_drop;
  logic [7:0]              key_out;
  logic [PW-1:0]           push_n;
  logic [SLOTS-1:0][7:0]   push_data;
  logic [CW-1:0]           q_count;

  kbd_cmd_decode #(.RSP_MAX(RSP_MAX)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .layout_sw(layout_sw), .q_clear(q_clear), .rsp_n(rsp_n), .rsp(rsp),
    .led_skip(led_skip), .ev_led_consume(ev_led_consume)
  );

  kbd_key_filter #(.LOCKS(LOCKS)) u_key (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .key_release(key_release), .key_kind(key_kind), .key_push(key_push),
    .key_out(key_out), .ev_key_hidden(ev_key_hidden)
  );

  // Command bytes first, key byte right after them
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k < RSP_MAX) begin : g_mix
      assign push_data[k] = (NW'(k) < rsp_n) ? rsp[k] : key_out;
    end else begin : g_key
      assign push_data[k] = key_out;
    end
  end
  assign push_n = PW'(rsp_n) + PW'(key_push);

  kbd_byte_queue #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_q (
    .clk(clk), .rst_n(rst_n), .clear(q_clear), .pop(pop), .push_n(push_n),
    .push_data(push_data), .rd_data(rd_data), .not_empty(not_empty),
    .count(q_count), .ev_drop(ev_drop)
  );
endmodule

// File: rtl/kbd_cmd_responder_sva.sv
module kbd_cmd_responder_sva #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [7:0]    cmd_byte,
  input logic          key_valid,
  input logic [6:0]    key_code,
  input logic          key_release,
  input logic [1:0]    key_kind,
  input logic          pop,
  input logic [7:0]    rd_data,
  input logic          not_empty,
  input logic [CW-1:0] q_count,
  input logic          led_skip
);
  logic plain_cmd;
  assign plain_cmd = cmd_valid && !led_skip;

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  assert_empty_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty |-> rd_data == 8'h00);

  assert_led_consume_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (led_skip && cmd_valid) |=> !led_skip);

  assert_ident_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_cmd && cmd_byte == 8'h01 && !key_valid) |=> (q_count == CW'(3) && rd_data == 8'hFF));

  assert_layout_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_cmd && (cmd_byte == 8'h07 || cmd_byte == 8'h0F) && !key_valid)
      |=> (q_count == CW'(2) && rd_data == 8'hFE));

  assert_ignored_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_cmd && !key_valid && !pop && cmd_byte != 8'h01 && cmd_byte != 8'h07 &&
     cmd_byte != 8'h0F) |=> q_count == $past(q_count));

  assert_key_encode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !cmd_valid && (key_kind == 2'd0 || key_kind == 2'd3) && !not_empty)
      |=> rd_data == {$past(key_release), $past(key_code)});
endmodule

bind kbd_cmd_responder kbd_cmd_responder_sva #(.DEPTH(DEPTH)) u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .key_valid(key_valid), .key_code(key_code), .key_release(key_release),
  .key_kind(key_kind), .pop(pop), .rd_data(rd_data), .not_empty(not_empty),
  .q_count(q_count), .led_skip(led_skip)
);

// File: tb/kbd_cmd_responder_test.sv
module kbd_cmd_responder_test;
  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, key_valid = 1'b0, key_release = 1'b0, pop = 1'b0;
  logic [7:0] cmd_byte = '0, layout_sw = 8'hFF, rd_data;
  logic [6:0] key_code = '0;
  logic [1:0] key_kind = '0;
  logic not_empty;

  int n_checks = 0, n_errors = 0;
  logic [7:0] exp_q[$];
  logic       m_skip = 1'b0;
  logic [1:0] m_tog[2] = '{2'd0, 2'd0};

  kbd_cmd_responder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .key_valid(key_valid), .key_code(key_code), .key_release(key_release),
    .key_kind(key_kind), .layout_sw(layout_sw), .pop(pop),
    .rd_data(rd_data), .not_empty(not_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic void m_push(input logic [7:0] b);
    if (exp_q.size() < QDEPTH) exp_q.push_back(b);
  endfunction

  function automatic void m_cmd(input logic [7:0] b);
    if (m_skip) m_skip = 1'b0;
    else if (b == 8'h01) begin
      exp_q.delete(); m_push(8'hFF); m_push(8'h04); m_push(8'h7F);
    end else if (b == 8'h0E) m_skip = 1'b1;
    else if (b == 8'h07 || b == 8'h0F) begin
      exp_q.delete(); m_push(8'hFE);
      m_push(layout_sw == 8'hFF ? 8'h21 : layout_sw);
    end
  endfunction

  function automatic void m_key(input logic [6:0] c, input logic rel, input logic [1:0] kind);
    logic emit = 1'b1;
    if (kind == 2'd1 || kind == 2'd2) begin
      int i = int'(kind) - 1;
      if (!rel) begin m_tog[i][0] = ~m_tog[i][0]; emit = (m_tog[i] != 2'd2); end
      else      begin m_tog[i][1] = ~m_tog[i][1]; emit = (m_tog[i] != 2'd3); end
    end
    if (emit) m_push({rel, c});
  endfunction

  // Driver: one event per cycle, expected bytes pushed to the scoreboard
  task automatic drive(input logic dc, input logic [7:0] b, input logic dk,
                       input logic [6:0] c, input logic rel, input logic [1:0] kind);
    @(negedge clk);
    cmd_valid = dc; cmd_byte = b; key_valid = dk; key_code = c;
    key_release = rel; key_kind = kind;
    if (dc) m_cmd(b);
    if (dk) m_key(c, rel, kind);
    @(negedge clk);
    cmd_valid = 1'b0; key_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    drive(1'b1, b, 1'b0, '0, 1'b0, 2'd0);
  endtask

  task automatic send_key(input logic [6:0] c, input logic rel, input logic [1:0] kind);
    drive(1'b0, '0, 1'b1, c, rel, kind);
  endtask

  // Monitor: pops the design and compares against the scoreboard
  task automatic drain(input string tag);
    while (exp_q.size() > 0) begin
      @(negedge clk);
      chk({tag, " not_empty"}, {7'd0, not_empty}, 8'd1);
      chk({tag, " byte"}, rd_data, exp_q.pop_front());
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
    end
    @(negedge clk);
    chk({tag, " drained"}, {7'd0, not_empty}, 8'd0);
    chk({tag, " empty head"}, rd_data, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 not_empty", {7'd0, not_empty}, 8'd0);
    chk("R1 rd_data", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {7'd0, not_empty}, 8'd0);

    send_cmd(8'h01);          drain("R2 ident R11");

    layout_sw = 8'h2B;
    send_cmd(8'h07);          drain("R4 layout 07");
    layout_sw = 8'hFF;
    send_cmd(8'h0F);          drain("R5 layout default");

    send_cmd(8'h0E);
    send_cmd(8'h01);
    @(negedge clk);
    chk("R3 led byte consumed", {7'd0, not_empty}, 8'd0);
    send_cmd(8'h01);          drain("R3 after skip");

    send_key(7'h12, 1'b0, 2'd0);
    send_cmd(8'h55);
    send_cmd(8'h00);          drain("R6 ignored cmd");

    send_key(7'h1D, 1'b0, 2'd0);
    send_key(7'h1D, 1'b1, 2'd3); drain("R7 press release");

    send_key(7'h77, 1'b0, 2'd1);
    send_key(7'h77, 1'b1, 2'd1);
    send_key(7'h62, 1'b0, 2'd2);
    send_key(7'h77, 1'b0, 2'd1);
    send_key(7'h77, 1'b1, 2'd1);
    send_key(7'h62, 1'b1, 2'd2); drain("R8 lock filter");

    for (int i = 0; i < 20; i++) send_key(7'(i + 1), 1'b0, 2'd0);
    drain("R9 full drop");

    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    chk("R10 empty pop head", rd_data, 8'h00);
    chk("R10 empty pop flag", {7'd0, not_empty}, 8'd0);
    send_key(7'h05, 1'b0, 2'd0); drain("R10 after empty pop");

    send_key(7'h31, 1'b0, 2'd0);
    send_key(7'h32, 1'b0, 2'd0);
    layout_sw = 8'h40;
    send_cmd(8'h07);          drain("R4 clears old");

    drive(1'b1, 8'h01, 1'b1, 7'h44, 1'b1, 2'd0); drain("R12 cmd then key");

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule